// File: doc/BRIEF.md
# Four-Function Shared-Adder ALU

This block is a purely combinational arithmetic/logic unit. It takes two operands and a two-bit function code, and it returns a result word and a carry flag. The four operations are bitwise AND, bitwise OR, addition and subtraction. The outputs settle directly from the inputs: the block has no clock, no reset and no storage.

Addition and subtraction share one ripple-carry adder. The low function bit has two jobs. It selects between the second operand and its bitwise complement at the adder input, and it also drives the adder carry-in. With the bit set, the adder computes `a + ~b + 1`, which is the two's-complement difference. The logic results go through a 2-to-1 selector steered by the low bit. A second 2-to-1 selector, steered by the high bit, then chooses between that logic result and the adder output.

The operand width is a parameter and defaults to 8 bits.

Top module: `alu_core`

## Requirements
- R1: With func_i = 2'b00, z_o equals a_i AND b_i bit by bit, and carry_o is 0.
- R2: With func_i = 2'b01, z_o equals a_i OR b_i bit by bit, and carry_o is 0.
- R3: With func_i = 2'b10, {carry_o, z_o} equals the 9-bit unsigned sum a_i + b_i. For example, 255 + 255 gives z_o = 8'b11111110 and carry_o = 1.
- R4: With func_i = 2'b11, z_o equals (a_i - b_i) mod 256. A negative difference appears in two's-complement form. For example, 100 - 145 gives 8'b11010011, and 155 - 110 gives 8'b00101101.
- R5: With func_i = 2'b11, carry_o is 1 exactly when a_i >= b_i as unsigned values (no borrow), and 0 when a borrow occurs.
- R6: Whenever func_i[1] = 0, carry_o is 0, whatever the operands are.
- R7: The outputs follow any change on a_i, b_i or func_i with no clock edge involved. Changing only func_i switches the result for the same operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 8 | First operand |
| b_i | input | 8 | Second operand (the subtrahend for SUB) |
| func_i | input | 2 | Function code: 00 AND, 01 OR, 10 ADD, 11 SUB |
| z_o | output | 8 | Result word |
| carry_o | output | 1 | Adder carry-out for ADD and SUB; 0 for the logic operations |

## Verification
The bench uses all-ones operands to expose a full carry ripple and carry-out. It uses opposed alternating bit patterns to tell AND from OR, and to tell an inverted operand from a plain one. Subtraction is tried with positive differences, negative differences and equal operands. These three cases separate a correct borrow flag from an inverted one, and a missing carry-in from a present one. A walking-one sweep over every function code, compared against an integer model, catches a wrong select bit or a swapped mux leg. Changing the function code while the operands stay fixed shows that the result follows the inputs directly.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [1:0] {
    FN_AND = 2'b00,
    FN_OR  = 2'b01,
    FN_ADD = 2'b10,
    FN_SUB = 2'b11
  } alu_fn_e;
endpackage

// File: rtl/alu_logic_unit.sv
module alu_logic_unit #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sel_or_i,
  output logic [WIDTH-1:0] y_o
);
  logic [WIDTH-1:0] and_w, or_w;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign and_w[i] = a_i[i] & b_i[i];
    assign or_w[i]  = a_i[i] | b_i[i];
    assign y_o[i]   = sel_or_i ? or_w[i] : and_w[i];
  end
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sub_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);
  logic [WIDTH-1:0] b_eff;
  logic [WIDTH:0]   c;

  // sub_i both inverts the operand and injects the +1
  assign c[0] = sub_i;

  for (genvar i = 0; i < WIDTH; i++) begin : g_fa
    assign b_eff[i]  = sub_i ? ~b_i[i] : b_i[i];
    assign sum_o[i]  = a_i[i] ^ b_eff[i] ^ c[i];
    assign c[i+1]    = (a_i[i] & b_eff[i]) | (c[i] & (a_i[i] ^ b_eff[i]));
  end

  assign cout_o = c[WIDTH];

  always_comb begin
    if (!sub_i) begin
      assert_add_sum_R3: assert ({cout_o, sum_o} == ({1'b0, a_i} + {1'b0, b_i}))
        else $error("adder sum mismatch");
    end else begin
      assert_sub_borrow_R5: assert (cout_o == (a_i >= b_i))
        else $error("borrow flag mismatch");
    end
  end
endmodule

// File: rtl/alu_result_mux.sv
module alu_result_mux #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] logic_i,
  input  logic [WIDTH-1:0] arith_i,
  input  logic             arith_cout_i,
  input  logic             sel_arith_i,
  output logic [WIDTH-1:0] z_o,
  output logic             carry_o
);
  assign z_o     = sel_arith_i ? arith_i : logic_i;
  assign carry_o = sel_arith_i & arith_cout_i;
endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [1:0]       func_i,
  output logic [WIDTH-1:0] z_o,
  output logic             carry_o
);
  logic [WIDTH-1:0] logic_res, arith_res;
  logic             arith_cout;

  alu_logic_unit #(.WIDTH(WIDTH)) i_logic (
    .a_i      (a_i),
    .b_i      (b_i),
    .sel_or_i (func_i[0]),
    .y_o      (logic_res)
  );

  alu_addsub #(.WIDTH(WIDTH)) i_addsub (
    .a_i    (a_i),
    .b_i    (b_i),
    .sub_i  (func_i[0]),
    .sum_o  (arith_res),
    .cout_o (arith_cout)
  );

  alu_result_mux #(.WIDTH(WIDTH)) i_mux (
    .logic_i      (logic_res),
    .arith_i      (arith_res),
    .arith_cout_i (arith_cout),
    .sel_arith_i  (func_i[1]),
    .z_o          (z_o),
    .carry_o      (carry_o)
  );

  always_comb begin
    case (alu_fn_e'(func_i))
      FN_AND: begin
        assert_and_R1: assert (z_o == (a_i & b_i)) else $error("AND result mismatch");
      end
      FN_OR: begin
        assert_or_R2: assert (z_o == (a_i | b_i)) else $error("OR result mismatch");
      end
      FN_SUB: begin
        assert_sub_R4: assert (z_o == WIDTH'(a_i - b_i)) else $error("SUB result mismatch");
      end
      default: ;
    endcase
    if (!func_i[1]) begin
      assert_logic_carry_R6: assert (carry_o == 1'b0) else $error("carry set on logic op");
    end
  end
endmodule

// File: tb/test_alu_core.sv
module test_alu_core;
  logic       clk = 1'b0;
  logic [7:0] a, b;
  logic [1:0] fn;
  logic [7:0] z;
  logic       co;
  int         n_run  = 0;
  int         n_fail = 0;
  bit         done   = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  alu_core i_alu_core (
    .a_i     (a),
    .b_i     (b),
    .func_i  (fn),
    .z_o     (z),
    .carry_o (co)
  );

  task automatic check(string req, logic [7:0] ez, logic ec);
    n_run++;
    if (z !== ez || co !== ec) begin
      n_fail++;
      $display("FAIL %s: fn=%b a=%h b=%h got z=%h c=%b exp z=%h c=%b",
               req, fn, a, b, z, co, ez, ec);
    end
  endtask

  // drive at posedge, sample at the following negedge
  task automatic apply(logic [1:0] f, logic [7:0] x, logic [7:0] y);
    @(posedge clk);
    fn = f; a = x; b = y;
    @(negedge clk);
  endtask

  task automatic expect_model(string req);
    int s;
    case (fn)
      2'b00: check(req, a & b, 1'b0);
      2'b01: check(req, a | b, 1'b0);
      2'b10: begin s = int'(a) + int'(b); check(req, s[7:0], s[8]); end
      default: begin
        s = int'(a) - int'(b);
        check(req, s[7:0], int'(a) >= int'(b));
      end
    endcase
  endtask

  task automatic test_initial();
    @(negedge clk);
    check("R1 initial zero", 8'h00, 1'b0);
  endtask

  task automatic test_and();
    apply(2'b00, 8'b10011011, 8'b01101110); check("R1", 8'b00001010, 1'b0);
    apply(2'b00, 8'hFF, 8'hFF);             check("R1 R6 ones", 8'hFF, 1'b0);
    apply(2'b00, 8'hAA, 8'h55);             check("R1", 8'h00, 1'b0);
  endtask

  task automatic test_or();
    apply(2'b01, 8'b01100100, 8'b10010001); check("R2", 8'b11110101, 1'b0);
    apply(2'b01, 8'hAA, 8'h55);             check("R2 R6", 8'hFF, 1'b0);
    apply(2'b01, 8'h00, 8'h00);             check("R2", 8'h00, 1'b0);
  endtask

  task automatic test_add();
    apply(2'b10, 8'hFF, 8'hFF); check("R3 ones", 8'b11111110, 1'b1);
    apply(2'b10, 8'h01, 8'hFF); check("R3 ripple", 8'h00, 1'b1);
    apply(2'b10, 8'd100, 8'd45); check("R3", 8'd145, 1'b0);
  endtask

  task automatic test_sub();
    apply(2'b11, 8'd155, 8'd110); check("R4 R5 pos", 8'b00101101, 1'b1);
    apply(2'b11, 8'd100, 8'd145); check("R4 R5 neg", 8'b11010011, 1'b0);
    apply(2'b11, 8'h5A, 8'h5A);   check("R5 equal", 8'h00, 1'b1);
    apply(2'b11, 8'h00, 8'hFF);   check("R4 R5", 8'h01, 1'b0);
    apply(2'b11, 8'hFF, 8'hFF);   check("R4 R5 ones", 8'h00, 1'b1);
  endtask

  task automatic test_sweep();
    for (int f = 0; f < 4; f++) begin
      for (int i = 0; i < 8; i++) begin
        apply(2'(f), 8'(1 << i), 8'(8'hC3 ^ (8'h80 >> i)));
        expect_model("R1 R2 R3 R4 R5 R6 sweep");
      end
    end
  endtask

  // R7: no clock edge between input change and sample
  task automatic test_comb();
    @(negedge clk);
    a = 8'hF0; b = 8'h3C; fn = 2'b00;
    #1 check("R7 and", 8'h30, 1'b0);
    fn = 2'b01;
    #1 check("R7 or", 8'hFC, 1'b0);
    fn = 2'b10;
    #1 check("R7 add", 8'h2C, 1'b1);
    fn = 2'b11;
    #1 check("R7 sub", 8'hB4, 1'b1);
  endtask

  initial begin
    a = '0; b = '0; fn = '0;
    test_initial();
    test_and();
    test_or();
    test_add();
    test_sub();
    test_sweep();
    test_comb();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: exp completion, got timeout");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule